// File: doc/BRIEF.md
# Row-Column Transpose Memory Controller

This block sits between the row pass and the column pass of an 8x8 two-dimensional DCT. The row pass streams each block in as 64 words through a valid/ready handshake. The column pass takes the same block out through a second valid/ready handshake, transposed: read word j of a block is write word `(j mod 8)*8 + j/8`. A single 64-word storage array holds the data. It has one write port and one read port, both usable in the same cycle, and a read of a word returns the value stored before any write to that word in the same cycle.

The transpose needs only one buffer because the addressing scan alternates between blocks. When a block is written in row-major order (address `{row,col}`), it is read in column-major order (address `{col,row}`). The next block is then written in column-major order, which is the same order the reader is freeing slots in, and it is read back in row-major order. The writer therefore follows the reader slot by slot, one block behind. An occupancy count stalls the writer whenever its next slot still holds a word the reader has not taken.

The read side is a two-state machine. `RD_IDLE` holds `rd_valid` low. The transition *fill-complete* (`RD_IDLE` to `RD_STREAM`) is taken when the 64th word of a block is being accepted. The transition *drain-complete* (`RD_STREAM` to `RD_IDLE`) is taken on the last read of a block, unless the next block finishes in that same cycle. In that case the transition *chain* (`RD_STREAM` to `RD_STREAM`) keeps the output streaming with no bubble.

Top module: `tpose_mem_ctrl`

## Requirements
- R1: In the first cycle after reset is released, `rd_valid` is 0 and `wr_ready` is 1.
- R2: `rd_valid` stays 0 until 64 words have been accepted on the write side. It becomes 1 in the cycle right after the clock edge that accepts the 64th word.
- R3: For every block, read word j (counted from 0 within the block) equals the write word with in-block index `(j mod 8)*8 + j/8`. Blocks come out in the order they went in, and no extra word appears.
- R4: The write scan starts row-major (address = row*8+col) and toggles between row-major and column-major only after the 64th word of a block is written. The read scan starts column-major and toggles only after the 64th word of a block is read.
- R5: When 64 words are stored unread and no read is accepted in the same cycle, `wr_ready` is 0, and a word offered on `wr_data` is neither stored nor seen at the output.
- R6: When 64 words are stored unread and a read is accepted in that cycle, `wr_ready` is 1. A word written to the slot being read in that cycle does not change the read data.
- R7: `rd_last` is 1 exactly on the 64th read word of each block while `rd_valid` is 1.
- R8: When the write side offers a word every cycle and `rd_ready` stays 1, the read side delivers one word per cycle with no idle cycle across block boundaries.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, the next cycle still has `rd_valid` at 1 and the same `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Row pass offers a word |
| wr_data | input | 16 | Word from the row pass, in row-major order within the block |
| wr_ready | output | 1 | Word is accepted on this edge if `wr_valid` is also 1 |
| rd_valid | output | 1 | A transposed word is available |
| rd_data | output | 16 | Word for the column pass |
| rd_ready | input | 1 | Column pass takes the word on this edge |
| rd_last | output | 1 | Marks the final word of a block |

## Verification
The case that matters is a write and a read landing in the same cycle. In the worst case they hit the same slot while the store is full, where the writer may only proceed because the reader is emptying that exact slot. The bench fills one block with the reader held off, confirms the writer is refused, and then releases both sides together so they run in lockstep over several blocks. Every word goes through a scoreboard that predicts the transposed order. A stale slot would show up as a data mismatch, and a missed write permission would show up as a broken one-word-per-cycle cadence. A final phase with random gaps on both sides makes the writer trail the reader by varying distances.

// File: rtl/tpose_pkg.sv
package tpose_pkg;

    typedef enum logic {
        RD_IDLE   = 1'b0,
        RD_STREAM = 1'b1
    } rd_state_e;

    typedef enum logic {
        SCAN_ROW = 1'b0,
        SCAN_COL = 1'b1
    } scan_mode_e;

endpackage

// File: rtl/tpose_scan_gen.sv
module tpose_scan_gen
    import tpose_pkg::*;
#(
    parameter int         SIDE      = 8,
    parameter scan_mode_e INIT_MODE = SCAN_ROW,
    localparam int SIDE_W = $clog2(SIDE),
    localparam int IDX_W  = 2 * SIDE_W,
    localparam int WORDS  = SIDE * SIDE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output scan_mode_e       mode,
    output logic [IDX_W-1:0] addr,
    output logic             last
);

    assign last = (idx == IDX_W'(WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= '0;
            mode <= INIT_MODE;
        end else if (step) begin
            if (last) begin
                idx  <= '0;
                mode <= (mode == SCAN_ROW) ? SCAN_COL : SCAN_ROW;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Column-major scan swaps the row and column halves of the index.
    always_comb begin
        unique case (mode)
            SCAN_ROW: addr = idx;
            SCAN_COL: addr = {idx[SIDE_W-1:0], idx[IDX_W-1:SIDE_W]};
        endcase
    end

endmodule

// File: rtl/tpose_ram.sv
module tpose_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read sees the contents before this cycle's write lands.
    assign rdata = mem[raddr];

endmodule

// File: rtl/tpose_flow_ctrl.sv
module tpose_flow_ctrl
    import tpose_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int OCC_W = $clog2(WORDS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic rd_ready,
    input  logic rd_end,
    output logic wr_ready,
    output logic wr_fire,
    output logic rd_valid,
    output logic rd_fire
);

    rd_state_e        state, state_nx;
    logic [OCC_W-1:0] occ, occ_nx;
    logic             occ_full_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_IDLE;
            occ   <= '0;
        end else begin
            state <= state_nx;
            occ   <= occ_nx;
        end
    end

    // Output process
    always_comb begin
        rd_valid = 1'b0;
        unique case (state)
            RD_IDLE:   rd_valid = 1'b0;
            RD_STREAM: rd_valid = 1'b1;
        endcase
        rd_fire  = rd_valid && rd_ready;
        wr_ready = (occ < OCC_W'(WORDS)) || rd_fire;
        wr_fire  = wr_valid && wr_ready;
    end

    always_comb begin
        unique case ({wr_fire, rd_fire})
            2'b10:   occ_nx = occ + 1'b1;
            2'b01:   occ_nx = occ - 1'b1;
            default: occ_nx = occ;
        endcase
        occ_full_nx = (occ_nx == OCC_W'(WORDS));
    end

    // Next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE: begin
                if (occ_full_nx) begin
                    state_nx = RD_STREAM;
                end
            end
            RD_STREAM: begin
                if (rd_fire && rd_end && !occ_full_nx) begin
                    state_nx = RD_IDLE;
                end
            end
        endcase
    end

endmodule

// File: rtl/tpose_mem_ctrl.sv
module tpose_mem_ctrl
    import tpose_pkg::*;
#(
    parameter int SIDE   = 8,
    parameter int DATA_W = 16,
    localparam int WORDS = SIDE * SIDE,
    localparam int IDX_W = 2 * $clog2(SIDE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_ready,
    output logic              rd_last
);

    logic             wr_fire, rd_fire;
    logic [IDX_W-1:0] wr_idx, wr_addr, rd_idx, rd_addr;
    logic             wr_end, rd_end;
    scan_mode_e       wr_mode, rd_mode;

    tpose_flow_ctrl #(.WORDS(WORDS)) u_flow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .rd_ready (rd_ready),
        .rd_end   (rd_end),
        .wr_ready (wr_ready),
        .wr_fire  (wr_fire),
        .rd_valid (rd_valid),
        .rd_fire  (rd_fire)
    );

    tpose_scan_gen #(.SIDE(SIDE), .INIT_MODE(SCAN_ROW)) u_wscan (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (wr_fire),
        .idx   (wr_idx),
        .mode  (wr_mode),
        .addr  (wr_addr),
        .last  (wr_end)
    );

    tpose_scan_gen #(.SIDE(SIDE), .INIT_MODE(SCAN_COL)) u_rscan (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rd_fire),
        .idx   (rd_idx),
        .mode  (rd_mode),
        .addr  (rd_addr),
        .last  (rd_end)
    );

    tpose_ram #(.DATA_W(DATA_W), .DEPTH(WORDS)) u_ram (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign rd_last = rd_valid && rd_end;

endmodule

// File: rtl/tpose_mem_ctrl_chk.sv
module tpose_mem_ctrl_chk
    import tpose_pkg::*;
#(
    parameter int SIDE   = 8,
    parameter int DATA_W = 16,
    localparam int WORDS = SIDE * SIDE,
    localparam int IDX_W = 2 * $clog2(SIDE),
    localparam int OCC_W = $clog2(WORDS + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_last,
    input scan_mode_e        wr_mode,
    input scan_mode_e        rd_mode,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [IDX_W-1:0]  rd_idx
);

    logic             wf, rf;
    logic [OCC_W-1:0] held;
    logic [OCC_W-1:0] wr_seen;
    logic [IDX_W-1:0] rd_pos;

    assign wf = wr_valid && wr_ready;
    assign rf = rd_valid && rd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held    <= '0;
            wr_seen <= '0;
            rd_pos  <= '0;
        end else begin
            held <= held + OCC_W'(wf) - OCC_W'(rf);
            if (wf && wr_seen != OCC_W'(WORDS)) begin
                wr_seen <= wr_seen + 1'b1;
            end
            if (rf) begin
                rd_pos <= rd_pos + 1'b1;
            end
        end
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_valid && wr_ready)); // R1

    AST_READ_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (wr_seen == OCC_W'(WORDS))); // R2

    AST_WR_SCAN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_mode) |-> $past(wf && wr_idx == IDX_W'(WORDS - 1))); // R4

    AST_RD_SCAN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_mode) |-> $past(rf && rd_idx == IDX_W'(WORDS - 1))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        held <= OCC_W'(WORDS)); // R5

    AST_LAST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_last == (rd_pos == IDX_W'(WORDS - 1)))); // R7

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9

endmodule

bind tpose_mem_ctrl tpose_mem_ctrl_chk #(.SIDE(SIDE), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .rd_last  (rd_last),
    .wr_mode  (wr_mode),
    .rd_mode  (rd_mode),
    .wr_idx   (wr_idx),
    .rd_idx   (rd_idx)
);

// File: tb/tpose_mem_ctrl_tb.sv
module tpose_mem_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SIDE       = 8;
    localparam int WORDS      = SIDE * SIDE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ready;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        rd_ready = 1'b0;
    logic        rd_last;

    int          n_checks = 0;
    int          n_errors = 0;
    int          cyc = 0;
    int          rd_seen = 0;
    int          last_fire = -1;
    bit          gap_chk = 0;
    bit          chk_first = 0;
    bit          chk_r6 = 0;
    bit          rnd_rd = 0;
    bit          hold_prev = 0;
    logic [15:0] hold_data = '0;
    logic [15:0] exp_q [$];

    tpose_mem_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_ready (rd_ready),
        .rd_last  (rd_last)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] word_of(input int blk, input int n);
        return 16'((blk << 8) | n);
    endfunction

    // Driver: predicts the transposed order, then feeds the block.
    task automatic send_block(input int blk, input bit gappy);
        for (int j = 0; j < WORDS; j++) begin
            exp_q.push_back(word_of(blk, (j % SIDE) * SIDE + j / SIDE));
        end
        for (int n = 0; n < WORDS; n++) begin
            bit acc;
            if (gappy && $urandom_range(0, 3) == 0) begin
                wr_valid = 1'b0;
                @(posedge clk);
                #1;
            end
            wr_valid = 1'b1;
            wr_data  = word_of(blk, n);
            do begin
                @(negedge clk);
                acc = wr_ready;
                if (chk_first) check(rd_valid == 1'b0, "R2 idle before fill", rd_valid, 0);
                if (chk_r6) begin
                    check(wr_ready == 1'b1, "R6 write allowed while full slot is read",
                          wr_ready, 1);
                    chk_r6 = 0;
                end
                @(posedge clk);
                #1;
            end while (!acc);
        end
        wr_valid = 1'b0;
    endtask

    // Random reader pacing
    always begin
        @(posedge clk);
        #1;
        if (rnd_rd) rd_ready = 1'($urandom_range(0, 1));
    end

    // Monitor: compares each delivered word with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_prev && rd_valid) begin
                check(rd_data == hold_data, "R9 data held under stall", rd_data, hold_data);
            end
            hold_prev = rd_valid && !rd_ready;
            hold_data = rd_data;
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected word", rd_data, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R3 transposed order", rd_data, e);
                end
                check(rd_last == ((rd_seen % WORDS) == WORDS - 1), "R7 last marker",
                      rd_last, ((rd_seen % WORDS) == WORDS - 1));
                if (gap_chk && last_fire >= 0) begin
                    check(cyc - last_fire == 1, "R8 one word per cycle", cyc - last_fire, 1);
                end
                last_fire = cyc;
                rd_seen++;
            end
        end
    end

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 5000) begin
            @(posedge clk);
            guard++;
        end
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        check(wr_ready == 1'b1, "R1 wr_ready after reset", wr_ready, 1);
        @(posedge clk);
        #1;

        // First block with the reader held off.
        chk_first = 1;
        send_block(0, 1'b0);
        chk_first = 0;
        wr_valid = 1'b1;
        wr_data  = 16'hDEAD;
        @(negedge clk);
        check(rd_valid == 1'b1, "R2 valid after fill", rd_valid, 1);
        check(wr_ready == 1'b0, "R5 writer refused when full", wr_ready, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(wr_ready == 1'b0, "R5 writer stays refused", wr_ready, 0);
        end

        // Release both sides together: lockstep on the same slots.
        @(posedge clk);
        #1;
        rd_ready  = 1'b1;
        chk_r6    = 1;
        gap_chk   = 1;
        last_fire = -1;
        send_block(1, 1'b0);
        send_block(2, 1'b0);
        send_block(3, 1'b0);
        drain();
        gap_chk = 0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R3 no extra block", rd_valid, 0);
        check(rd_seen == 4 * WORDS, "R3 word count", rd_seen, 4 * WORDS);

        // Random pacing on both sides.
        @(posedge clk);
        #1;
        rnd_rd = 1;
        send_block(4, 1'b1);
        send_block(5, 1'b1);
        send_block(6, 1'b1);
        drain();
        rnd_rd = 0;
        @(posedge clk);
        #1;
        rd_ready = 1'b0;
        check(rd_seen == 7 * WORDS, "R3 word count after random phase", rd_seen, 7 * WORDS);
        check(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule